// File: doc/BRIEF.md
# Masked Pattern and Trigger Matcher

This block watches a wide sample bus and compares every valid sample against two independent value/mask pairs. The filter pair decides which samples are of interest and raises a pattern-hit strobe. The trigger pair decides whether a trigger fires. Each pair is loaded through a narrow write port, one register-wide word at a time. The default sample is 256 bits wide and each register word is 32 bits, so each value and each mask takes eight words.

Four static configuration inputs shape the comparison. One input chooses the comparison mode. In value mode the raw sample is compared. In toggle mode the compared quantity is the bitwise change since the previous valid sample. A second input lets a pattern hit request a timestamp. A third input arms the trigger. A fourth input lets a trigger request a timestamp. All three outputs are registered single-cycle strobes. Timestamp generation and packet assembly are left to neighbouring logic.

Top module: `dsb_match_unit`

## Requirements
- R1: While `rst_i` is high at a clock edge, all three outputs are low after that edge, and all value and mask words are cleared to zero.
- R2: A write with `cfg_we_i` high stores `cfg_wdata_i` into bits `[idx*REG_W +: REG_W]` of the bank that `cfg_bank_i` selects. The bank encoding is 0 for filter value, 1 for filter mask, 2 for trigger value and 3 for trigger mask. Other words are unchanged.
- R3: In value mode (`toggle_mode_i`=0), a valid sample hits the filter when every bit set in the filter mask equals the matching filter value bit. In that case `pat_hit_o` is high one cycle later.
- R4: A pair whose mask is all zero matches every valid sample.
- R5: In toggle mode, the compared quantity is the sample XOR the previous valid sample. The previous sample is zero after reset and is updated by every valid sample in either mode.
- R6: `trig_o` pulses one cycle after a valid sample only when `trig_type_i` is 1 and the trigger pair matches under the same comparison mode.
- R7: `ts_req_o` is high exactly when (`pat_hit_o` is high and `ts_en_i` was 1 with the sample) or (`trig_o` is high and `trig_ts_i` was 1 with the sample).
- R8: All outputs are low in the cycle after a clock edge at which `smp_vld_i` was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| cfg_we_i | input | 1 | Register word write strobe |
| cfg_bank_i | input | 2 | Bank select: 0 filter value, 1 filter mask, 2 trigger value, 3 trigger mask |
| cfg_idx_i | input | IDX_W | Word index within the bank |
| cfg_wdata_i | input | REG_W | Write data |
| toggle_mode_i | input | 1 | 0 compares values, 1 compares toggles |
| ts_en_i | input | 1 | Pattern hit requests a timestamp |
| trig_type_i | input | 1 | Arms the trigger |
| trig_ts_i | input | 1 | Trigger requests a timestamp |
| smp_vld_i | input | 1 | Sample valid |
| smp_i | input | SAMPLE_W | Sample bus |
| pat_hit_o | output | 1 | Filter pattern hit strobe |
| trig_o | output | 1 | Trigger strobe |
| ts_req_o | output | 1 | Timestamp request strobe |

## Verification
The hardest case to reach is toggle mode. There, whether a sample hits depends on the sample that came before it, so a hit depends on history as well as on the current input and the register contents. The bench uses a narrow instance with two words per bank. It sweeps every value/mask nibble combination against a run of samples in both modes, and it keeps its own copy of the previous valid sample. It also spreads the three control bits across the sweep, so that each mix of arming and timestamp enables meets both hits and misses.

// File: rtl/dsb_match_pkg.sv
package dsb_match_pkg;
  typedef enum logic [1:0] {
    BANK_FILT_VAL = 2'd0,
    BANK_FILT_MSK = 2'd1,
    BANK_TRIG_VAL = 2'd2,
    BANK_TRIG_MSK = 2'd3
  } bank_sel_e;

  function automatic logic is_bank(input logic [1:0] sel, input bank_sel_e which);
    return sel == which;
  endfunction
endpackage

// File: rtl/dsb_mask_bank.sv
module dsb_mask_bank #(
  parameter int SAMPLE_W = 256,
  parameter int REG_W    = 32,
  localparam int NREG    = SAMPLE_W / REG_W,
  localparam int IDX_W   = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic                wr_val_i,
  input  logic                wr_msk_i,
  input  logic [IDX_W-1:0]    idx_i,
  input  logic [REG_W-1:0]    wdata_i,
  output logic [SAMPLE_W-1:0] value_o,
  output logic [SAMPLE_W-1:0] mask_o
);
  for (genvar g = 0; g < NREG; g++) begin : g_word
    logic sel;
    assign sel = (idx_i == IDX_W'(g));
    always_ff @(posedge clk_i) begin
      if (rst_i) begin
        value_o[g*REG_W +: REG_W] <= '0;
        mask_o[g*REG_W +: REG_W]  <= '0;
      end else begin
        if (wr_val_i && sel) value_o[g*REG_W +: REG_W] <= wdata_i;
        if (wr_msk_i && sel) mask_o[g*REG_W +: REG_W]  <= wdata_i;
      end
    end
  end
endmodule

// File: rtl/dsb_sample_prep.sv
module dsb_sample_prep #(
  parameter int SAMPLE_W = 256
) (
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic                vld_i,
  input  logic                toggle_i,
  input  logic [SAMPLE_W-1:0] smp_i,
  output logic [SAMPLE_W-1:0] cmp_o
);
  logic [SAMPLE_W-1:0] prev_q;

  function automatic logic [SAMPLE_W-1:0] toggles(input logic [SAMPLE_W-1:0] cur,
                                                  input logic [SAMPLE_W-1:0] old);
    return cur ^ old;
  endfunction

  always_ff @(posedge clk_i) begin
    if (rst_i)      prev_q <= '0;
    else if (vld_i) prev_q <= smp_i;
  end

  assign cmp_o = toggle_i ? toggles(smp_i, prev_q) : smp_i;
endmodule

// File: rtl/dsb_pattern_cmp.sv
module dsb_pattern_cmp #(
  parameter int SAMPLE_W = 256
) (
  input  logic [SAMPLE_W-1:0] data_i,
  input  logic [SAMPLE_W-1:0] value_i,
  input  logic [SAMPLE_W-1:0] mask_i,
  output logic                match_o
);
  function automatic logic masked_eq(input logic [SAMPLE_W-1:0] d,
                                     input logic [SAMPLE_W-1:0] v,
                                     input logic [SAMPLE_W-1:0] m);
    return (d & m) == (v & m);
  endfunction

  assign match_o = masked_eq(data_i, value_i, mask_i);
endmodule

// File: rtl/dsb_match_unit.sv
module dsb_match_unit
  import dsb_match_pkg::*;
#(
  parameter int SAMPLE_W = 256,
  parameter int REG_W    = 32,
  localparam int NREG    = SAMPLE_W / REG_W,
  localparam int IDX_W   = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic                cfg_we_i,
  input  logic [1:0]          cfg_bank_i,
  input  logic [IDX_W-1:0]    cfg_idx_i,
  input  logic [REG_W-1:0]    cfg_wdata_i,
  input  logic                toggle_mode_i,
  input  logic                ts_en_i,
  input  logic                trig_type_i,
  input  logic                trig_ts_i,
  input  logic                smp_vld_i,
  input  logic [SAMPLE_W-1:0] smp_i,
  output logic                pat_hit_o,
  output logic                trig_o,
  output logic                ts_req_o
);
  logic [SAMPLE_W-1:0] filt_val, filt_msk, trig_val, trig_msk, cmp_data;
  logic filt_match, trig_match, hit_evt, trig_evt, ts_evt;

  dsb_mask_bank #(.SAMPLE_W(SAMPLE_W), .REG_W(REG_W)) u_filt_bank (
    .clk_i(clk_i), .rst_i(rst_i),
    .wr_val_i(cfg_we_i && is_bank(cfg_bank_i, BANK_FILT_VAL)),
    .wr_msk_i(cfg_we_i && is_bank(cfg_bank_i, BANK_FILT_MSK)),
    .idx_i(cfg_idx_i), .wdata_i(cfg_wdata_i),
    .value_o(filt_val), .mask_o(filt_msk)
  );

  dsb_mask_bank #(.SAMPLE_W(SAMPLE_W), .REG_W(REG_W)) u_trig_bank (
    .clk_i(clk_i), .rst_i(rst_i),
    .wr_val_i(cfg_we_i && is_bank(cfg_bank_i, BANK_TRIG_VAL)),
    .wr_msk_i(cfg_we_i && is_bank(cfg_bank_i, BANK_TRIG_MSK)),
    .idx_i(cfg_idx_i), .wdata_i(cfg_wdata_i),
    .value_o(trig_val), .mask_o(trig_msk)
  );

  dsb_sample_prep #(.SAMPLE_W(SAMPLE_W)) u_prep (
    .clk_i(clk_i), .rst_i(rst_i), .vld_i(smp_vld_i),
    .toggle_i(toggle_mode_i), .smp_i(smp_i), .cmp_o(cmp_data)
  );

  dsb_pattern_cmp #(.SAMPLE_W(SAMPLE_W)) u_filt_cmp (
    .data_i(cmp_data), .value_i(filt_val), .mask_i(filt_msk), .match_o(filt_match)
  );

  dsb_pattern_cmp #(.SAMPLE_W(SAMPLE_W)) u_trig_cmp (
    .data_i(cmp_data), .value_i(trig_val), .mask_i(trig_msk), .match_o(trig_match)
  );

  // Named events feeding the output registers.
  assign hit_evt  = smp_vld_i && filt_match;
  assign trig_evt = smp_vld_i && trig_type_i && trig_match;
  assign ts_evt   = (hit_evt && ts_en_i) || (trig_evt && trig_ts_i);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      pat_hit_o <= 1'b0;
      trig_o    <= 1'b0;
      ts_req_o  <= 1'b0;
    end else begin
      pat_hit_o <= hit_evt;
      trig_o    <= trig_evt;
      ts_req_o  <= ts_evt;
    end
  end
endmodule

// File: rtl/dsb_match_chk.sv
module dsb_match_chk #(
  parameter int SAMPLE_W = 256
) (
  input logic                clk_i,
  input logic                rst_i,
  input logic                smp_vld_i,
  input logic                ts_en_i,
  input logic                trig_type_i,
  input logic                trig_ts_i,
  input logic [SAMPLE_W-1:0] filt_msk,
  input logic [SAMPLE_W-1:0] trig_msk,
  input logic                pat_hit_o,
  input logic                trig_o,
  input logic                ts_req_o
);
  assert_reset_quiet_R1: assert property (@(posedge clk_i)
    rst_i |=> (!pat_hit_o && !trig_o && !ts_req_o));

  assert_zero_mask_hit_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    (smp_vld_i && filt_msk == '0) |=> pat_hit_o);

  assert_zero_mask_trig_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    (smp_vld_i && trig_type_i && trig_msk == '0) |=> trig_o);

  assert_trig_armed_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    trig_o |-> $past(trig_type_i));

  assert_ts_source_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    ts_req_o |-> ((pat_hit_o && $past(ts_en_i)) || (trig_o && $past(trig_ts_i))));

  assert_idle_quiet_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    !smp_vld_i |=> (!pat_hit_o && !trig_o && !ts_req_o));
endmodule

bind dsb_match_unit dsb_match_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk_i(clk_i), .rst_i(rst_i), .smp_vld_i(smp_vld_i), .ts_en_i(ts_en_i),
  .trig_type_i(trig_type_i), .trig_ts_i(trig_ts_i),
  .filt_msk(filt_msk), .trig_msk(trig_msk),
  .pat_hit_o(pat_hit_o), .trig_o(trig_o), .ts_req_o(ts_req_o)
);

// File: tb/tb_dsb_match_unit.sv
module tb_dsb_match_unit;
  localparam int SW = 8;
  localparam int RW = 4;

  logic clk = 1'b0;
  logic rst_i = 1'b1;
  logic cfg_we_i = 1'b0;
  logic [1:0] cfg_bank_i = '0;
  logic [0:0] cfg_idx_i = '0;
  logic [RW-1:0] cfg_wdata_i = '0;
  logic toggle_mode_i = 1'b0, ts_en_i = 1'b0, trig_type_i = 1'b0, trig_ts_i = 1'b0;
  logic smp_vld_i = 1'b0;
  logic [SW-1:0] smp_i = '0;
  logic pat_hit_o, trig_o, ts_req_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [SW-1:0] prev_m = '0;
  logic [SW-1:0] fv, fm, tv, tm;

  always #2.5 clk = ~clk;

  dsb_match_unit #(.SAMPLE_W(SW), .REG_W(RW)) dut (
    .clk_i(clk), .rst_i(rst_i), .cfg_we_i(cfg_we_i), .cfg_bank_i(cfg_bank_i),
    .cfg_idx_i(cfg_idx_i), .cfg_wdata_i(cfg_wdata_i), .toggle_mode_i(toggle_mode_i),
    .ts_en_i(ts_en_i), .trig_type_i(trig_type_i), .trig_ts_i(trig_ts_i),
    .smp_vld_i(smp_vld_i), .smp_i(smp_i),
    .pat_hit_o(pat_hit_o), .trig_o(trig_o), .ts_req_o(ts_req_o)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b (time %0t)", req, act, exp, $time);
    end
  endtask

  // Bench model: a bit mismatches when masked and differing.
  function automatic logic model_eq(input logic [SW-1:0] d, input logic [SW-1:0] v,
                                    input logic [SW-1:0] m);
    return ((d ^ v) & m) == '0;
  endfunction

  task automatic wr(input logic [1:0] bank, input logic idx, input logic [RW-1:0] d);
    @(negedge clk);
    cfg_we_i = 1'b1; cfg_bank_i = bank; cfg_idx_i = idx; cfg_wdata_i = d;
    @(negedge clk);
    cfg_we_i = 1'b0;
  endtask

  task automatic load(input logic [SW-1:0] a, input logic [SW-1:0] b,
                      input logic [SW-1:0] c, input logic [SW-1:0] d);
    for (int w = 0; w < 2; w++) begin
      wr(2'd0, w[0], a[w*RW +: RW]);
      wr(2'd1, w[0], b[w*RW +: RW]);
      wr(2'd2, w[0], c[w*RW +: RW]);
      wr(2'd3, w[0], d[w*RW +: RW]);
    end
    fv = a; fm = b; tv = c; tm = d;
  endtask

  // Drive one valid sample, check the pulse, then an idle cycle.
  task automatic put(input logic [SW-1:0] s, input string hreq);
    logic [SW-1:0] cd;
    logic eh, et;
    cd = toggle_mode_i ? (s ^ prev_m) : s;
    eh = model_eq(cd, fv, fm);
    et = trig_type_i && model_eq(cd, tv, tm);
    @(negedge clk);
    smp_vld_i = 1'b1; smp_i = s;
    @(negedge clk);
    check(hreq, pat_hit_o, eh);
    check("R6", trig_o, et);
    check("R7", ts_req_o, (eh && ts_en_i) || (et && trig_ts_i));
    smp_vld_i = 1'b0;
    prev_m = s;
    @(negedge clk);
    check("R8", pat_hit_o | trig_o | ts_req_o, 1'b0);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    fv = '0; fm = '0; tv = '0; tm = '0;
    smp_vld_i = 1'b1; smp_i = 8'hFF;
    repeat (3) @(negedge clk);
    check("R1", pat_hit_o | trig_o | ts_req_o, 1'b0);
    rst_i = 1'b0; smp_vld_i = 1'b0;

    // R4: registers cleared by reset, zero masks match anything
    trig_type_i = 1'b1;
    put(8'h5A, "R4");
    put(8'hC3, "R4");

    // R2: only the upper word of the filter mask is set
    load(8'h30, 8'hF0, 8'h00, 8'h00);
    put(8'h3F, "R2");
    put(8'h20, "R2");
    put(8'h03, "R2");

    // Sweep in both modes with varied control bits
    for (int mode = 0; mode < 2; mode++) begin
      toggle_mode_i = mode[0];
      for (int v = 0; v < 16; v++) begin
        for (int m = 0; m < 16; m++) begin
          ts_en_i = v[0];
          trig_type_i = m[1] | v[3];
          trig_ts_i = v[2] ^ m[0];
          load({v[3:0], v[3:0] ^ 4'h5}, {m[3:0], ~m[3:0]},
               {v[3:0], v[3:0]} ^ 8'hA3, {m[3:0], m[3:0]} ^ {4'h0, 4'(v)});
          for (int s = 0; s < 6; s++) begin
            put({4'(s * 5 + v), 4'(s ^ m)}, mode[0] ? "R5" : "R3");
          end
        end
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule